// File: doc/BRIEF.md
# Sensor Firmware Download Sequencer

This block is a host-side controller that places a firmware image into an optical motion sensor over a four-wire serial link. After a start pulse it holds the sensor in reset for a set time. It then performs two unlock writes to the sensor's enable register, with one sensor frame of idle time between them. Next it opens a single burst write to the sensor's load register and streams the image through it.

Image bytes come from a valid/ready source. The sequencer takes one byte only when the previous byte has finished shifting and a minimum idle gap has passed. If the source has no byte ready, the sequencer waits with the burst still open. After the last byte it releases chip select, holds it high long enough for the sensor to leave burst mode, and then waits for a settle interval. At the end it pulses `done`, after which the host may read the image identifier. A byte counter shows progress.

Every serial transfer is sent MSB first. The clock idles high, the data line changes while the clock is low, and the sensor samples on the rising clock edge. A register write is a command byte followed by a data byte. The command byte is the 7-bit register address with bit 7 set to 1.

Top module: `fwload_seq`

## Requirements
- R1: While reset is held and right after it is released, `spi_cs_n`=1, `spi_sck`=1, `sensor_rst`=0, `img_ready`=0, `done`=0 and `bytes_sent`=0.
- R2: After `start`, `sensor_rst` is high for at least RESET_CYC consecutive cycles, and it rises before chip select first goes low.
- R3: The first chip-select-low transaction carries exactly two bytes: 0x94 (write flag in bit 7, register 0x14) and then 0x1D. The bytes are sent MSB first and sampled on the rising edge of `spi_sck`.
- R4: Chip select stays high for at least FRAME_CYC cycles between the end of the first transaction and the start of the second.
- R5: The second transaction carries exactly two bytes: 0x94 and then 0x18.
- R6: The third transaction carries 0xE0 (write flag with register 0x60), followed by the image bytes in the order they were accepted, all under one chip-select-low period and with no repeated command byte.
- R7: Within the burst, the time from the last rising `spi_sck` edge of one byte to the first falling edge of the next byte is at least GAP_US*CLK_MHZ cycles. This applies after the command byte as well.
- R8: When a byte is due and `img_valid` is low, `img_ready` stays high, chip select stays low and `spi_sck` stays high until the source supplies a byte.
- R9: Exactly IMG_LEN bytes are accepted. After that, `img_ready` never rises again, and a source that keeps `img_valid` high causes no further serial bytes.
- R10: After the last image byte, chip select stays high. `done` rises no sooner than (EXIT_US+SETTLE_US)*CLK_MHZ cycles after chip select rises, and it is high for exactly one cycle.
- R11: `bytes_sent` is cleared by `start` and increases by one as each image byte finishes shifting. It reads IMG_LEN when `done` is pulsed.
- R12: A `start` pulse while a download is running has no effect: there is no second reset pulse and no extra transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a download (used only when idle) |
| img_data | input | 8 | Image byte from the source |
| img_valid | input | 1 | Source has a byte on `img_data` |
| img_ready | output | 1 | Sequencer will take a byte this cycle |
| sensor_rst | output | 1 | Hardware reset to the sensor, active high |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Serial data to the sensor |
| bytes_sent | output | $clog2(IMG_LEN+1) | Image bytes completed |
| done | output | 1 | One-cycle pulse when the ID may be read |

## Verification
The bench builds the sequencer with CLK_MHZ=1, RESET_CYC=4, FRAME_CYC=50, SCK_HALF=2 and IMG_LEN=6. With these values each microsecond is one cycle, so the 10-cycle gap, the 4-cycle exit and the 100-cycle settle can be measured directly. A six-byte image is long enough to reach the final-byte cutoff and the extra-byte handling in a few thousand cycles. A 40-cycle source stall lets the bench check that chip select stays low and that a long gap is still counted.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_UNLK_A,
        ST_UNLK_D,
        ST_FRAME,
        ST_ARM_A,
        ST_ARM_D,
        ST_REL,
        ST_LOAD_A,
        ST_GAP,
        ST_FETCH,
        ST_LOAD_D,
        ST_EXIT,
        ST_SETTLE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       go;
        logic [7:0] data;
    } tx_req_t;

    localparam logic [6:0] ENABLE_REG  = 7'h14;
    localparam logic [6:0] LOAD_REG    = 7'h60;
    localparam logic [7:0] CODE_UNLOCK = 8'h1D;
    localparam logic [7:0] CODE_ARM    = 8'h18;

    function automatic logic [7:0] wr_cmd(input logic [6:0] addr);
        return {1'b1, addr};
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic holds_cs(input seq_state_e s);
        case (s)
            ST_UNLK_A, ST_UNLK_D, ST_ARM_A, ST_ARM_D,
            ST_LOAD_A, ST_GAP, ST_FETCH, ST_LOAD_D: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic sends_byte(input seq_state_e s);
        case (s)
            ST_UNLK_A, ST_UNLK_D, ST_ARM_A, ST_ARM_D,
            ST_LOAD_A, ST_LOAD_D: return 1'b1;
            default:              return 1'b0;
        endcase
    endfunction

    function automatic logic is_timed(input seq_state_e s);
        case (s)
            ST_RST, ST_FRAME, ST_REL, ST_GAP,
            ST_EXIT, ST_SETTLE: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fwl_timer.sv
module fwl_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (val == '0) ? '0 : val - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

    // R7: a running wait counts down by exactly one per cycle
    a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/fwl_spi_tx.sv
module fwl_spi_tx
    import fwl_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  tx_req_t req,
    output logic    sck,
    output logic    mosi,
    output logic    fin
);
    localparam int HW = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HRELOAD = HW'(HALF - 1);

    logic          busy;
    logic          phase;
    logic [2:0]    bitn;
    logic [7:0]    sr;
    logic [HW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= 1'b1;
            bitn  <= '0;
            sr    <= '0;
            tmr   <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!busy) begin
                if (req.go) begin
                    busy  <= 1'b1;
                    sr    <= req.data;
                    phase <= 1'b0;
                    bitn  <= '0;
                    tmr   <= HRELOAD;
                end
            end else if (tmr != '0) begin
                tmr <= tmr - HW'(1);
            end else if (!phase) begin
                phase <= 1'b1;
                tmr   <= HRELOAD;
            end else if (bitn == 3'd7) begin
                busy <= 1'b0;
                fin  <= 1'b1;
            end else begin
                bitn  <= bitn + 3'd1;
                sr    <= {sr[6:0], 1'b0};
                phase <= 1'b0;
                tmr   <= HRELOAD;
            end
        end
    end

    assign sck  = busy ? phase : 1'b1;
    assign mosi = sr[7];

    // R3: data is held while the clock is high, so the sensor's rising-edge sample is clean
    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck) && !$past(req.go)) |-> $stable(mosi));

    // R3: a byte always completes with the clock back at its idle level
    a_r3_fin_idle: assert property (@(posedge clk) disable iff (rst)
        fin |-> sck);

endmodule

// File: rtl/fwload_seq.sv
module fwload_seq
    import fwl_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int RESET_CYC = 500,
    parameter int FRAME_CYC = 50000,
    parameter int SCK_HALF  = 25,
    parameter int IMG_LEN   = 1986,
    parameter int GAP_US    = 10,
    parameter int EXIT_US   = 4,
    parameter int SETTLE_US = 100,
    localparam int CW       = $clog2(IMG_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    img_data,
    input  logic          img_valid,
    output logic          img_ready,
    output logic          sensor_rst,
    output logic          spi_cs_n,
    output logic          spi_sck,
    output logic          spi_mosi,
    output logic [CW-1:0] bytes_sent,
    output logic          done
);
    localparam int GAP_CYC    = GAP_US * CLK_MHZ;
    localparam int EXIT_CYC   = EXIT_US * CLK_MHZ;
    localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
    localparam int TMAX       = imax(imax(RESET_CYC, FRAME_CYC),
                                     imax(GAP_CYC, imax(EXIT_CYC, SETTLE_CYC)));
    localparam int TW         = $clog2(TMAX + 1);

    seq_state_e    state, nxt;
    logic          entry;
    logic          tmr_zero;
    logic          tmr_load;
    logic [TW-1:0] tval;
    logic          wait_over;
    logic          tx_fin;
    logic [7:0]    img_q;
    logic          last_byte;
    tx_req_t       req;

    assign wait_over = tmr_zero && !entry;
    assign last_byte = (bytes_sent == CW'(IMG_LEN - 1));

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start)     nxt = ST_RST;
            ST_RST:    if (wait_over) nxt = ST_UNLK_A;
            ST_UNLK_A: if (tx_fin)    nxt = ST_UNLK_D;
            ST_UNLK_D: if (tx_fin)    nxt = ST_FRAME;
            ST_FRAME:  if (wait_over) nxt = ST_ARM_A;
            ST_ARM_A:  if (tx_fin)    nxt = ST_ARM_D;
            ST_ARM_D:  if (tx_fin)    nxt = ST_REL;
            ST_REL:    if (wait_over) nxt = ST_LOAD_A;
            ST_LOAD_A: if (tx_fin)    nxt = ST_GAP;
            ST_GAP:    if (wait_over) nxt = ST_FETCH;
            ST_FETCH:  if (img_valid) nxt = ST_LOAD_D;
            ST_LOAD_D: if (tx_fin)    nxt = last_byte ? ST_EXIT : ST_GAP;
            ST_EXIT:   if (wait_over) nxt = ST_SETTLE;
            ST_SETTLE: if (wait_over) nxt = ST_DONE;
            ST_DONE:                  nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            entry      <= 1'b0;
            bytes_sent <= '0;
            img_q      <= '0;
        end else begin
            state <= nxt;
            entry <= (nxt != state);
            if (state == ST_IDLE && start) begin
                bytes_sent <= '0;
            end else if (state == ST_LOAD_D && tx_fin) begin
                bytes_sent <= bytes_sent + CW'(1);
            end
            if (state == ST_FETCH && img_valid) begin
                img_q <= img_data;
            end
        end
    end

    always_comb begin
        case (state)
            ST_RST:    tval = TW'(RESET_CYC);
            ST_FRAME:  tval = TW'(FRAME_CYC);
            ST_GAP:    tval = TW'(GAP_CYC);
            ST_SETTLE: tval = TW'(SETTLE_CYC);
            default:   tval = TW'(EXIT_CYC);
        endcase
    end

    assign tmr_load = entry && is_timed(state);

    always_comb begin
        req.go = entry && sends_byte(state);
        case (state)
            ST_UNLK_D: req.data = CODE_UNLOCK;
            ST_ARM_D:  req.data = CODE_ARM;
            ST_LOAD_A: req.data = wr_cmd(LOAD_REG);
            ST_LOAD_D: req.data = img_q;
            default:   req.data = wr_cmd(ENABLE_REG);
        endcase
    end

    fwl_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tval),
        .zero (tmr_zero)
    );

    fwl_spi_tx #(.HALF(SCK_HALF)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .fin  (tx_fin)
    );

    assign sensor_rst = (state == ST_RST);
    assign spi_cs_n   = !holds_cs(state);
    assign img_ready  = (state == ST_FETCH);
    assign done       = (state == ST_DONE);

    // R2: the sensor is never selected while it is held in reset
    a_r2_rst_no_cs: assert property (@(posedge clk) disable iff (rst)
        sensor_rst |-> spi_cs_n);

    // R8: while waiting for the source, the burst stays open and the clock idles
    a_r8_wait_open: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> (!spi_cs_n && spi_sck));

    // R9: the byte count never passes the image length
    a_r9_count_cap: assert property (@(posedge clk) disable iff (rst)
        bytes_sent <= CW'(IMG_LEN));

    // R10: completion is a single-cycle pulse
    a_r10_done_one: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: progress moves by one step at a time, or restarts from zero
    a_r11_step: assert property (@(posedge clk) disable iff (rst)
        (bytes_sent != $past(bytes_sent)) |->
            ((bytes_sent == $past(bytes_sent) + CW'(1)) || (bytes_sent == '0)));

    // R12: the reset pulse is entered only from idle
    a_r12_rst_from_idle: assert property (@(posedge clk) disable iff (rst)
        (sensor_rst && !$past(sensor_rst)) |-> ($past(state) == ST_IDLE));

endmodule

// File: tb/sim_fwload_seq.sv
module sim_fwload_seq;
    localparam int CLK_MHZ    = 1;
    localparam int RESET_CYC  = 4;
    localparam int FRAME_CYC  = 50;
    localparam int SCK_HALF   = 2;
    localparam int IMG_LEN    = 6;
    localparam int GAP_CYC    = 10 * CLK_MHZ;
    localparam int EXIT_CYC   = 4 * CLK_MHZ;
    localparam int SETTLE_CYC = 100 * CLK_MHZ;
    localparam int CW         = $clog2(IMG_LEN + 1);
    localparam int NEXP       = 5 + IMG_LEN;
    localparam int WD_CYC     = 20000;

    localparam logic [7:0] IMG [IMG_LEN] = '{8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A, 8'hC3};
    localparam int         DLY [IMG_LEN] = '{0, 2, 0, 40, 1, 0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    img_data = '0;
    logic          img_valid = 1'b0;
    logic          img_ready, sensor_rst, spi_cs_n, spi_sck, spi_mosi, done;
    logic [CW-1:0] bytes_sent;

    always #5 clk = ~clk;

    fwload_seq #(
        .CLK_MHZ(CLK_MHZ), .RESET_CYC(RESET_CYC), .FRAME_CYC(FRAME_CYC),
        .SCK_HALF(SCK_HALF), .IMG_LEN(IMG_LEN)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .img_data(img_data),
        .img_valid(img_valid), .img_ready(img_ready), .sensor_rst(sensor_rst),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .bytes_sent(bytes_sent), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        case (k)
            0, 2:    return 8'h94;
            1:       return 8'h1D;
            3:       return 8'h18;
            4:       return 8'hE0;
            default: return IMG[k-5];
        endcase
    endfunction

    function automatic int exp_txn(input int k);
        return (k < 2) ? 1 : ((k < 4) ? 2 : 3);
    endfunction

    // serial monitor, sampled between clock edges
    int cyc = 0;
    logic p_sck = 1'b1, p_cs = 1'b1, p_rst = 1'b0, p_done = 1'b0;
    int nbit = 0, nbytes = 0, cs_falls = 0, cs_rises = 0;
    logic [7:0] sr = '0;
    logic [7:0] got [32];
    int gtxn [32];
    int first_fall [32];
    int last_rise [32];
    int cs_fall_cyc [8];
    int cs_rise_cyc [8];
    int rst_rises = 0, rst_rise_cyc = -1, rst_run = 0, rst_width = 0;
    int done_cnt = 0, done_cyc = 0, done_run = 0, done_width = 0;
    int acc_cnt = 0, bad_ready = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!spi_cs_n && p_cs) begin
                if (cs_falls < 8) cs_fall_cyc[cs_falls] = cyc;
                cs_falls++;
            end
            if (spi_cs_n && !p_cs) begin
                if (cs_rises < 8) cs_rise_cyc[cs_rises] = cyc;
                cs_rises++;
            end
            if (!spi_cs_n && !spi_sck && p_sck && nbit == 0 && nbytes < 32)
                first_fall[nbytes] = cyc;
            if (!spi_cs_n && spi_sck && !p_sck) begin
                sr = {sr[6:0], spi_mosi};
                nbit++;
                if (nbit == 8) begin
                    if (nbytes < 32) begin
                        got[nbytes]       = sr;
                        gtxn[nbytes]      = cs_falls;
                        last_rise[nbytes] = cyc;
                    end
                    nbytes++;
                    nbit = 0;
                end
            end
            if (sensor_rst) begin
                if (!p_rst) begin
                    rst_rises++;
                    if (rst_rise_cyc < 0) rst_rise_cyc = cyc;
                    rst_run = 0;
                end
                rst_run++;
                if (rst_run > rst_width) rst_width = rst_run;
            end
            if (done) begin
                if (!p_done) begin
                    done_cnt++;
                    done_cyc = cyc;
                    done_run = 0;
                end
                done_run++;
                done_width = done_run;
            end
            if (acc_cnt == IMG_LEN && img_ready) bad_ready++;
        end
        p_sck  = spi_sck;
        p_cs   = spi_cs_n;
        p_rst  = sensor_rst;
        p_done = done;
    end

    initial begin
        repeat (WD_CYC) @(negedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs in reset and just after release
        chk(spi_cs_n == 1 && spi_sck == 1, "R1 cs/sck in reset", {spi_cs_n, spi_sck}, 3);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1 && spi_sck == 1, "R1 cs/sck idle", {spi_cs_n, spi_sck}, 3);
        chk(sensor_rst == 0 && img_ready == 0 && done == 0, "R1 rst/ready/done idle",
            {sensor_rst, img_ready, done}, 0);
        chk(bytes_sent == 0, "R1 bytes_sent", int'(bytes_sent), 0);

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // image source: one stimulus vector per byte, walked in order
        for (int i = 0; i < IMG_LEN; i++) begin
            while (!img_ready) @(negedge clk);
            if (i == 2) begin
                start = 1'b1;  // R12: start while busy
                @(negedge clk);
                start = 1'b0;
            end
            for (int d = 0; d < DLY[i]; d++) begin
                @(negedge clk);
                if (i == 3 && d == DLY[i] / 2) begin
                    chk(!spi_cs_n && img_ready && spi_sck, "R8 stall keeps burst open",
                        {spi_cs_n, img_ready, spi_sck}, 3'b011);
                    chk(bytes_sent == CW'(3), "R11 count mid-burst", int'(bytes_sent), 3);
                end
            end
            img_data  = IMG[i];
            img_valid = 1'b1;
            @(negedge clk);
            acc_cnt++;
            img_valid = 1'b0;
        end
        // R9: a source that keeps offering bytes after the image
        img_data  = 8'hA5;
        img_valid = 1'b1;

        while (done_cnt == 0) @(negedge clk);
        chk(bytes_sent == CW'(IMG_LEN), "R11 count at done", int'(bytes_sent), IMG_LEN);
        repeat (30) @(negedge clk);

        // R3 R5 R6: byte stream and transaction framing
        chk(nbytes == NEXP, "R9 serial byte total", nbytes, NEXP);
        for (int k = 0; k < NEXP; k++) begin
            string tag;
            tag = (k < 2) ? "R3 unlock write" : ((k < 4) ? "R5 arm write" : "R6 burst load");
            chk(got[k] == exp_byte(k), tag, int'(got[k]), int'(exp_byte(k)));
            chk(gtxn[k] == exp_txn(k), tag, gtxn[k], exp_txn(k));
        end
        // R7: idle gap before every burst data byte
        for (int k = 4; k < NEXP - 1; k++)
            chk(first_fall[k+1] - last_rise[k] >= GAP_CYC, "R7 inter-byte gap",
                first_fall[k+1] - last_rise[k], GAP_CYC);
        chk(first_fall[8] - last_rise[7] >= DLY[3], "R8 stall lengthens gap",
            first_fall[8] - last_rise[7], DLY[3]);
        // R2: reset pulse
        chk(rst_width >= RESET_CYC, "R2 reset width", rst_width, RESET_CYC);
        chk(rst_rise_cyc >= 0 && rst_rise_cyc < cs_fall_cyc[0], "R2 reset before select",
            rst_rise_cyc, cs_fall_cyc[0]);
        // R4: frame wait
        chk(cs_fall_cyc[1] - cs_rise_cyc[0] >= FRAME_CYC, "R4 frame wait",
            cs_fall_cyc[1] - cs_rise_cyc[0], FRAME_CYC);
        // R9: nothing after the image
        chk(bad_ready == 0, "R9 no ready after last", bad_ready, 0);
        // R10: exit, settle and done pulse
        chk(cs_falls == 3 && cs_rises == 3, "R10 cs released", cs_falls, 3);
        chk(done_cyc - cs_rise_cyc[2] >= EXIT_CYC + SETTLE_CYC, "R10 exit plus settle",
            done_cyc - cs_rise_cyc[2], EXIT_CYC + SETTLE_CYC);
        chk(done_cnt == 1 && done_width == 1, "R10 done single pulse", done_width, 1);
        // R12: no restart
        chk(rst_rises == 1, "R12 one reset pulse", rst_rises, 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule